// File: doc/BRIEF.md
# Multiplexed Sampling Sequencer with Settling Discard

This block drives the select lines of a four-input analog multiplexer that sits in front of one shared converter. It visits the inputs in a fixed rotation. Each time the multiplexer moves, the converter's output needs time to settle, so the block ignores a programmable number of conversion results before it trusts any sample from the newly selected input. It then keeps a programmable number of samples, each labelled with its input number, and hands them to a downstream waveform path over a valid/ready stream.

The stream never holds up the sequencer. If the downstream side is still holding a previous sample when a new trusted sample arrives, the new sample is lost and a sticky per-input flag records the loss. Both the discard count and the keep count are sampled at each switch, so a change made during a visit does not alter the window already in progress.

Top module: `mux_settle_seq`

## Requirements
- R1: After reset, `mux_sel` is 0, `out_valid` is 0 and every bit of `ovf` is 0.
- R2: `mux_sel` visits inputs in the order 0, 1, 2, 3, 0, and it advances by exactly one, only on the clock edge that captures the last kept sample of a visit.
- R3: After every switch, including the wrap from input 3 back to input 0, the first `cfg_discard` conversion strobes are dropped and never appear on the output.
- R4: With `cfg_discard` equal to 0, every conversion strobe of a visit produces an output sample.
- R5: Each visit keeps `cfg_keep` samples. A value of 0 is treated as 1.
- R6: A forwarded sample carries on `out_data` the converter word captured with it, and on `out_chan` the value of `mux_sel` at the strobe that produced it. The sample appears with `out_valid` high one clock after that strobe.
- R7: A new value on `cfg_discard` or `cfg_keep` takes effect for the visit that begins at the next switch. The values present on the first clock after reset govern the first visit.
- R8: When a kept sample arrives while `out_valid` is high and `out_ready` is low, the sample is dropped. Bit k of `ovf` is then set, where k is the input being sampled, and stays set until reset. The sequencer still counts the sample and advances as usual.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_chan` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_discard | input | CW | Results to drop after each switch |
| cfg_keep | input | CW | Samples to keep per visit (0 treated as 1) |
| mux_sel | output | 2 | Multiplexer select |
| cnv_done | input | 1 | One-cycle strobe: a conversion result is present |
| cnv_data | input | DW | Converter result word |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | DW | Forwarded sample |
| out_chan | output | 2 | Input tag of the forwarded sample |
| ovf | output | 4 | Sticky per-input drop flags |

## Verification
The hardest situation to reach from the ports is a change to the discard count while a settling window is partly used up. In that case the old window must still run to its end, and the new value must apply only at the following switch. The bench gets there by releasing reset with a window of two, letting one strobe be dropped, and then writing zero. It then checks that the next strobe is still dropped, that the third strobe is forwarded, and that the next input forwards its very first strobe. The drop path is reached by lowering `out_ready` while a sample is held and then sending the next visit's strobe.

// File: rtl/mux_settle_seq.sv
`timescale 1ns/1ps
module mux_settle_seq #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_discard,
  input  logic [CW-1:0] cfg_keep,
  output logic [1:0]    mux_sel,
  input  logic          cnv_done,
  input  logic [DW-1:0] cnv_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [1:0]    out_chan,
  output logic [3:0]    ovf
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          init_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] seen_q, kept_q, win_q, keep_q;
  logic          vld_q;
  logic [DW-1:0] dat_q;
  logic [1:0]    tag_q;
  logic [3:0]    ovf_q;

  logic [CW-1:0] keep_eff, win_use, keep_use;
  logic          kept_smp, last_smp, slot_full;

  assign keep_eff  = (cfg_keep == '0) ? ONE : cfg_keep;
  assign win_use   = init_q ? cfg_discard : win_q;
  assign keep_use  = init_q ? keep_eff : keep_q;
  assign kept_smp  = cnv_done && (seen_q >= win_use);
  assign last_smp  = kept_smp && (kept_q == keep_use - ONE);
  assign slot_full = vld_q && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      sel_q  <= '0;
      seen_q <= '0;
      kept_q <= '0;
      win_q  <= '0;
      keep_q <= ONE;
    end else begin
      init_q <= 1'b0;
      if (init_q || last_smp) begin
        win_q  <= cfg_discard;
        keep_q <= keep_eff;
      end
      if (cnv_done) begin
        if (!kept_smp) begin
          seen_q <= seen_q + ONE;
        end else if (last_smp) begin
          seen_q <= '0;
          kept_q <= '0;
          sel_q  <= sel_q + 2'd1;
        end else begin
          kept_q <= kept_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      tag_q <= '0;
      ovf_q <= '0;
    end else begin
      if (kept_smp && !slot_full) begin
        vld_q <= 1'b1;
        dat_q <= cnv_data;
        tag_q <= sel_q;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
      if (kept_smp && slot_full) ovf_q[sel_q] <= 1'b1;
    end
  end

  assign mux_sel   = sel_q;
  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_chan  = tag_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/mux_settle_seq_chk.sv
`timescale 1ns/1ps
module mux_settle_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnv_done,
  input logic [1:0]    mux_sel,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [1:0]    out_chan,
  input logic [3:0]    ovf
);
  // R2
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mux_sel != $past(mux_sel)) |-> (mux_sel == 2'($past(mux_sel) + 2'd1)));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_done |=> $stable(mux_sel));

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(out_valid)) |-> $past(cnv_done));

  // R6
  tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(out_valid)) |-> (out_chan == $past(mux_sel)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));
endmodule

bind mux_settle_seq mux_settle_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_done(cnv_done), .mux_sel(mux_sel),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_chan(out_chan), .ovf(ovf)
);

// File: tb/tb_mux_settle_seq.sv
`timescale 1ns/1ps
module tb_mux_settle_seq;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_discard = '0, cfg_keep = 8'd1;
  logic [1:0] mux_sel;
  logic cnv_done = 1'b0;
  logic [DW-1:0] cnv_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [1:0] out_chan;
  logic [3:0] ovf;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_settle_seq #(.DW(DW), .CW(CW)) dut (.*);

  // {discard, keep, conversions, expected forwarded count}
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'd1, 8'd16, 8'd8},
    {8'd0, 8'd1, 8'd8,  8'd8},
    {8'd3, 8'd2, 8'd20, 8'd8},
    {8'd2, 8'd3, 8'd25, 8'd15},
    {8'd1, 8'd0, 8'd12, 8'd6}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic conv(input logic [DW-1:0] d);
    cnv_data = d; cnv_done = 1'b1;
    @(negedge clk);
    cnv_done = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1
    chk(mux_sel == 2'd0, "R1 mux_sel", mux_sel, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(ovf == 4'd0, "R1 ovf", ovf, 0);

    for (int v = 0; v < NV; v++) begin
      int d, k, n, ef, vis, fwd;
      d = VEC[v][31:24]; k = VEC[v][23:16]; n = VEC[v][15:8]; ef = VEC[v][7:0];
      cfg_discard = CW'(d); cfg_keep = CW'(k);
      out_ready = 1'b1;
      do_reset();
      if (k == 0) k = 1;
      vis = d + k;
      fwd = 0;
      for (int i = 0; i < n; i++) begin
        int ch;
        bit keep;
        ch = (i / vis) % 4;
        keep = (i % vis) >= d;
        chk(mux_sel == 2'(ch), "R2 select order", mux_sel, ch);
        conv(DW'(v * 256 + i));
        if (keep) begin
          fwd++;
          chk(out_valid == 1'b1, "R4 kept sample valid", out_valid, 1);
          chk(out_data == DW'(v * 256 + i), "R6 data", out_data, v * 256 + i);
          chk(out_chan == 2'(ch), "R6 channel tag", out_chan, ch);
        end else begin
          chk(out_valid == 1'b0, "R3 discarded sample", out_valid, 0);
        end
        @(negedge clk);
      end
      chk(fwd == ef && mux_sel == 2'((n / vis) % 4), "R5 kept per visit", fwd, ef);
    end

    // R7: change of the window mid-visit applies at the next switch
    cfg_discard = 8'd2; cfg_keep = 8'd1; out_ready = 1'b1;
    do_reset();
    conv(16'h0101); @(negedge clk);
    chk(out_valid == 1'b0, "R7 first discard", out_valid, 0);
    cfg_discard = 8'd0;
    conv(16'h0102);
    chk(out_valid == 1'b0, "R7 old window still active", out_valid, 0);
    @(negedge clk);
    conv(16'h0103);
    chk(out_valid == 1'b1 && out_chan == 2'd0, "R7 kept after old window", out_valid, 1);
    @(negedge clk);
    conv(16'h0104);
    chk(out_valid == 1'b1 && out_chan == 2'd1 && out_data == 16'h0104,
        "R7 new window at next switch", out_data, 16'h0104);
    @(negedge clk);

    // R8 / R9: drop while output held, sequencer keeps going
    cfg_discard = 8'd0; cfg_keep = 8'd1; out_ready = 1'b1;
    do_reset();
    out_ready = 1'b0;
    conv(16'h00A0);
    chk(out_valid == 1'b1 && out_data == 16'h00A0, "R8 first sample held", out_data, 16'h00A0);
    conv(16'h00B1);
    chk(ovf == 4'b0010, "R8 overflow flag set for channel 1", ovf, 2);
    chk(mux_sel == 2'd2, "R8 sequencer not stalled", mux_sel, 2);
    chk(out_data == 16'h00A0 && out_chan == 2'd0, "R9 held data stable", out_data, 16'h00A0);
    chk(out_valid == 1'b1, "R9 held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 consumed when ready", out_valid, 0);
    conv(16'h00C2);
    chk(out_valid == 1'b1 && out_chan == 2'd2, "R8 next sample forwarded", out_chan, 2);
    chk(ovf == 4'b0010, "R8 overflow sticky", ovf, 2);
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule